// File: doc/BRIEF.md
# Virtual Pixel Window Buffer

This block sits between the vertical and horizontal passes of a separable image scaler. The vertical pass produces one "virtual" pixel per source column of the current output row. The horizontal pass needs four neighbouring virtual pixels for every output sample. The buffer keeps the eight most recent virtual pixels of the current line in a shift window, together with a count of how many pixels the line has received so far. From that count it serves any four consecutive columns that are still held.

When the image is enlarged, the horizontal pass reuses each virtual pixel for several output samples, so the buffer fills faster than it drains. The block absorbs this rate difference by holding off the producer. When the next push would evict the oldest column still requested, a stall flag stops the vertical pass. A line-start pulse empties the column count before each new line.

Top module: `vpix_window_buf`

## Requirements
- R1: After synchronous reset the line is empty: `rd_hit` is 0, `rd_taps` is all zero and `wr_stall` is 0 for a requested column of 0.
- R2: A pixel is accepted on a clock edge where `wr_valid` is 1, `wr_stall` is 0 and `line_start` is 0. It becomes the newest column, whose index equals the number of pixels accepted earlier in the line.
- R3: `line_start` empties the line, so the next accepted pixel is column 0. It takes priority over a write in the same cycle, and that write is dropped.
- R4: With N pixels accepted in the line and requested base column c, `rd_hit` is 1 exactly when c+4 <= N and c+8 >= N.
- R5: While `rd_hit` is 1, tap k (bits [8k+7:8k] of `rd_taps`, k = 0..3) holds the pixel of column c+k.
- R6: While `rd_hit` is 0, `rd_taps` is all zero.
- R7: `wr_stall` is 1 whenever N >= c+8, that is, when the newest column is at least 7 past c.
- R8: A write presented while `wr_stall` is 1 changes nothing: the served taps and the hit flag stay as before.
- R9: Once LINE_MAX pixels have been accepted in a line, `wr_stall` is 1 and further writes are dropped until `line_start`.
- R10: For a 2x horizontal enlargement, where output sample x requests base column min(x/2, LINE_MAX-4) and the producer pushes whenever it is not stalled, every hit delivers the reference virtual-pixel line. Every output sample is eventually served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Empties the line before a new row |
| wr_valid | input | 1 | Vertical pass offers a virtual pixel |
| wr_data | input | PIX_W | Offered virtual pixel |
| wr_stall | output | 1 | Holds off the vertical pass |
| rd_col | input | COL_W | Base column requested by the horizontal pass |
| rd_taps | output | TAPS*PIX_W | Four virtual pixels, tap k in bits [8k+7:8k] |
| rd_hit | output | 1 | All four requested columns are present |

## Verification
The embedded properties check the following on every cycle:
- the column count never passes the line length;
- the count restarts after a line start;
- the count advances by one per accepted push;
- the count freezes while a push is refused;
- a hit never occurs with fewer than four pixels held.

The scenario tasks are needed for the rest. They show which column each tap actually carries, that evicted columns miss, and that dropped writes leave the served data intact. They also run a full 2x enlargement against a reference line, which is the only place where the stall-and-hit handshake is seen to make progress without losing a pixel.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
    parameter int PIX_W     = 8;
    parameter int WIN_DEPTH = 8;
    parameter int TAPS      = 4;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic hit;
        logic stall;
    } win_status_t;

    // ring-free slot index for tap k of base column c, given fill count f
    function automatic int unsigned slot_of(input int unsigned f,
                                            input int unsigned c,
                                            input int unsigned k);
        return (WIN_DEPTH + c + k - f) % WIN_DEPTH;
    endfunction
endpackage

// File: rtl/vpb_window.sv
module vpb_window
    import vpb_pkg::*;
#(
    parameter int DEPTH = WIN_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  pix_t                    din,
    output logic [DEPTH-1:0][PIX_W-1:0] win
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == DEPTH - 1) begin : g_top
                always_ff @(posedge clk) begin
                    if (rst)           win[i] <= '0;
                    else if (shift_en) win[i] <= din;
                end
            end else begin : g_mid
                always_ff @(posedge clk) begin
                    if (rst)           win[i] <= '0;
                    else if (shift_en) win[i] <= win[i+1];
                end
            end
        end
    endgenerate

    AST_NEWEST_ON_TOP: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> win[DEPTH-1] == $past(din)); // R2
    AST_OLDER_MOVE_DOWN: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> win[0] == $past(win[1])); // R2
endmodule

// File: rtl/vpb_col_tracker.sv
module vpb_col_tracker #(
    parameter int LINE_MAX = 1024,
    localparam int CNT_W   = $clog2(LINE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             push,
    output logic [CNT_W-1:0] fill,
    output logic             full
);
    always_ff @(posedge clk) begin
        if (rst || line_start) fill <= '0;
        else if (push)         fill <= fill + 1'b1;
    end

    assign full = (fill == CNT_W'(LINE_MAX));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(LINE_MAX)); // R9
    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
        line_start |=> fill == '0); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (push && !line_start) |=> fill == CNT_W'($past(fill) + 1'b1)); // R2
endmodule

// File: rtl/vpb_select.sv
module vpb_select
    import vpb_pkg::*;
#(
    parameter int LINE_MAX = 1024,
    localparam int CNT_W   = $clog2(LINE_MAX + 1),
    localparam int COL_W   = $clog2(LINE_MAX),
    localparam int EW      = CNT_W + 2,
    localparam int IDX_W   = $clog2(WIN_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CNT_W-1:0]              fill,
    input  logic                          full,
    input  logic [COL_W-1:0]              rd_col,
    input  logic [WIN_DEPTH-1:0][PIX_W-1:0] win,
    output win_status_t                   status,
    output logic [TAPS*PIX_W-1:0]         taps
);
    logic [EW-1:0] f_e, c_e;

    assign f_e = EW'(fill);
    assign c_e = EW'(rd_col);

    always_comb begin
        status.hit   = (c_e + EW'(TAPS) <= f_e) && (f_e <= c_e + EW'(WIN_DEPTH));
        status.stall = full || (f_e >= c_e + EW'(WIN_DEPTH));
    end

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            logic [EW-1:0]    pos;
            logic [IDX_W-1:0] idx;
            assign pos = EW'(WIN_DEPTH) + c_e + EW'(k) - f_e;
            assign idx = pos[IDX_W-1:0];
            assign taps[k*PIX_W +: PIX_W] = status.hit ? win[idx] : '0;
        end
    endgenerate

    AST_HIT_NEEDS_TAPS: assert property (@(posedge clk) disable iff (rst)
        status.hit |-> fill >= CNT_W'(TAPS)); // R4
endmodule

// File: rtl/vpix_window_buf.sv
module vpix_window_buf
    import vpb_pkg::*;
#(
    parameter int LINE_MAX = 1024,
    localparam int CNT_W   = $clog2(LINE_MAX + 1),
    localparam int COL_W   = $clog2(LINE_MAX)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_start,
    input  logic                  wr_valid,
    input  logic [PIX_W-1:0]      wr_data,
    output logic                  wr_stall,
    input  logic [COL_W-1:0]      rd_col,
    output logic [TAPS*PIX_W-1:0] rd_taps,
    output logic                  rd_hit
);
    logic                          push;
    logic [CNT_W-1:0]              fill;
    logic                          full;
    logic [WIN_DEPTH-1:0][PIX_W-1:0] win;
    win_status_t                   status;

    assign push     = wr_valid && !status.stall && !line_start;
    assign wr_stall = status.stall;
    assign rd_hit   = status.hit;

    vpb_window #(.DEPTH(WIN_DEPTH)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (push),
        .din      (wr_data),
        .win      (win)
    );

    vpb_col_tracker #(.LINE_MAX(LINE_MAX)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .push       (push),
        .fill       (fill),
        .full       (full)
    );

    vpb_select #(.LINE_MAX(LINE_MAX)) u_select (
        .clk    (clk),
        .rst    (rst),
        .fill   (fill),
        .full   (full),
        .rd_col (rd_col),
        .win    (win),
        .status (status),
        .taps   (rd_taps)
    );

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_stall && !line_start) |=> fill == $past(fill)); // R8
endmodule

// File: tb/sim_vpix_window_buf.sv
module sim_vpix_window_buf;
    localparam int LINE = 32;
    localparam int W    = 8;
    localparam int CW   = $clog2(LINE);

    logic          clk = 0;
    logic          rst = 1;
    logic          line_start = 0;
    logic          wr_valid = 0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_stall;
    logic [CW-1:0] rd_col = '0;
    logic [4*W-1:0] rd_taps;
    logic          rd_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vpix_window_buf #(.LINE_MAX(LINE)) u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_stall(wr_stall), .rd_col(rd_col),
        .rd_taps(rd_taps), .rd_hit(rd_hit)
    );

    function automatic logic [W-1:0] pix(input int seed, input int col);
        return W'(col * 29 + seed * 71 + 3);
    endfunction

    function automatic logic [4*W-1:0] quad(input int seed, input int c);
        return {pix(seed, c + 3), pix(seed, c + 2), pix(seed, c + 1), pix(seed, c)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // one clock: drive at negedge, return at next negedge
    task automatic step(input logic ls, input logic wv, input logic [W-1:0] wd);
        line_start = ls; wr_valid = wv; wr_data = wd;
        @(negedge clk);
        line_start = 0; wr_valid = 0;
    endtask

    task automatic look(input int c);
        rd_col = CW'(c);
        #1;
    endtask

    task automatic t_reset();
        look(0);
        chk("R1 hit after reset", 64'(rd_hit), 64'd0);
        chk("R1 taps after reset", 64'(rd_taps), 64'd0);
        chk("R1 stall after reset", 64'(wr_stall), 64'd0);
    endtask

    task automatic t_fill_window();
        step(1, 0, '0);
        look(0);
        for (int i = 0; i < 8; i++) step(0, 1, pix(1, i));
        look(0);
        chk("R7 stall at newest-c=7", 64'(wr_stall), 64'd1);
        look(1);
        chk("R7 no stall at newest-c=6", 64'(wr_stall), 64'd0);
        for (int c = 0; c <= 4; c++) begin
            look(c);
            chk("R4 hit inside window", 64'(rd_hit), 64'd1);
            chk("R5 tap order", 64'(rd_taps), 64'(quad(1, c)));
        end
        look(5);
        chk("R4 miss beyond newest", 64'(rd_hit), 64'd0);
        chk("R6 taps zero on miss", 64'(rd_taps), 64'd0);
        look(0);
        step(0, 1, 8'hEE);
        look(0);
        chk("R8 stalled write ignored, taps", 64'(rd_taps), 64'(quad(1, 0)));
        look(4);
        chk("R8 stalled write ignored, newest", 64'(rd_taps), 64'(quad(1, 4)));
        look(1);
        step(0, 1, pix(1, 8));
        look(0);
        chk("R4 evicted column misses", 64'(rd_hit), 64'd0);
        look(1);
        chk("R5 taps after shift", 64'(rd_taps), 64'(quad(1, 1)));
        look(5);
        chk("R2 new pixel is newest column", 64'(rd_taps), 64'(quad(1, 5)));
    endtask

    task automatic t_restart();
        look(0);
        step(1, 1, 8'h55);
        look(0);
        chk("R3 line empty after start", 64'(rd_hit), 64'd0);
        chk("R3 no stall after start", 64'(wr_stall), 64'd0);
        for (int i = 0; i < 4; i++) step(0, 1, pix(2, i));
        look(0);
        chk("R3 first pixel is column 0", 64'(rd_taps), 64'(quad(2, 0)));
        look(1);
        chk("R3 write during start dropped", 64'(rd_hit), 64'd0);
    endtask

    task automatic t_upscale();
        int mf = 0;
        int x  = 0;
        step(1, 0, '0);
        while (x < 2 * LINE) begin
            int  c;
            bit  eh, es;
            c  = (x / 2 > LINE - 4) ? LINE - 4 : x / 2;
            look(c);
            wr_valid = (mf < LINE);
            wr_data  = pix(3, mf);
            #1;
            eh = (c + 4 <= mf) && (c + 8 >= mf);
            es = (mf >= LINE) || (mf >= c + 8);
            chk("R10 hit flag in stream", 64'(rd_hit), 64'(eh));
            chk("R7 stall flag in stream", 64'(wr_stall), 64'(es));
            if (eh) chk("R10 taps match reference", 64'(rd_taps), 64'(quad(3, c)));
            @(negedge clk);
            wr_valid = 0;
            if (mf < LINE && !es) mf++;
            if (eh) x++;
        end
        chk("R10 whole line consumed", 64'(mf), 64'(LINE));
    endtask

    task automatic t_capacity();
        step(1, 0, '0);
        look(LINE - 4);
        for (int i = 0; i < LINE; i++) step(0, 1, pix(4, i));
        look(LINE - 4);
        chk("R9 stall at full line", 64'(wr_stall), 64'd1);
        chk("R9 last taps", 64'(rd_taps), 64'(quad(4, LINE - 4)));
        step(0, 1, 8'hAA);
        look(LINE - 4);
        chk("R9 write past end dropped", 64'(rd_taps), 64'(quad(4, LINE - 4)));
        chk("R9 hit kept", 64'(rd_hit), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_fill_window();
        t_restart();
        t_upscale();
        t_capacity();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule